// File: doc/BRIEF.md
# Audio Clock Coast Event Controller

This block sits beside the audio clock-recovery loop of a digital video-link receiver. It watches the link status and decides when the loop must stop tracking and coast. While coasting, the loop's frequency control word is frozen in a holding register and its integrator is told not to update, so the recovered audio master clock stays steady for as long as the disturbance lasts.

Six conditions can start a coast, and each one has its own enable bit in a mask register. Three of them are levels: the link PLL has lost lock, the link clock shows irregular pulses, or the selected port reports no clock. Three of them are change events: the active port select has moved, the N value in a new clock-regeneration packet differs from the last one, or the CTS value has moved by more than a programmable threshold. Comparisons of CTS and N happen only on the packet strobe. Each enabled cause also sets a sticky bit that software clears by writing 1. Coasting ends only after every enabled cause has stayed quiet for a programmable number of sample-rate ticks.

Top module: `audio_coast_ctrl`

## Requirements
- R1: After reset `coast` is 0, `cause` is 0, `integ_en` is 1, all six causes are enabled, and the first `acr_strobe` after reset raises no CTS or N event.
- R2: Mask and cause bit positions: bit 6 link clock irregular (`clk_irreg`=1), bit 5 PLL unlocked (`pll_lock`=0), bit 3 CTS change, bit 2 N change, bit 1 port change, bit 0 no clock on the selected port. Bit 4 is reserved: writing it has no effect and it always reads 0 in `cause`.
- R3: A cause whose mask bit is 0 neither requests coasting nor sets its `cause` bit. A mask write (`mask_we`=1) takes effect from the following cycle.
- R4: On `acr_strobe`, once a previous value is stored, the CTS event fires when |`cts_in` − stored CTS| is strictly greater than `cts_thresh`; a difference equal to the threshold raises nothing. The stored value is replaced on every strobe.
- R5: On `acr_strobe`, once a previous value is stored, any difference between `n_in` and the stored N raises the N event.
- R6: A change of `port_sel` from one cycle to the next raises the port-change event in the cycle of the change.
- R7: The no-clock event is the inverse of `clk_det[port_sel]` for ports 0 to 3 (A to D); a `port_sel` of 4 to 7 counts as no clock.
- R8: When any enabled cause is present in a cycle, `coast` is 1 from the next cycle on.
- R9: `coast` falls only on an `fs_tick` cycle, once `release_ticks` ticks (a value of 0 acts as 1) have passed with no enabled cause; any enabled cause restarts the count.
- R10: While `coast` is 0, `freq_out` takes `freq_in` one cycle later; while `coast` is 1, `freq_out` holds its value and `integ_en` is 0.
- R11: An enabled cause sets its `cause` bit, which stays set until a 1 is written to that bit through `cause_clr`; a cause present in the same cycle as the clear keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acr_strobe | input | 1 | New clock-regeneration packet received; CTS and N are valid |
| cts_in | input | 20 | Received CTS value |
| n_in | input | 20 | Received N value |
| cts_thresh | input | 6 | CTS change threshold |
| port_sel | input | 3 | Active port select |
| clk_det | input | 4 | Per-port clock-detect flags, bit 0 = port A |
| pll_lock | input | 1 | Link PLL locked |
| clk_irreg | input | 1 | Link clock has irregular or missing pulses |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 7 | Mask write data |
| cause_clr | input | 7 | Write-1-to-clear strobes for the cause bits |
| fs_tick | input | 1 | One-cycle pulse at the audio sample rate |
| release_ticks | input | 8 | Quiet ticks required before coasting ends |
| freq_in | input | 24 | Frequency word from the loop filter |
| coast | output | 1 | Coast request |
| cause | output | 7 | Sticky cause register |
| freq_out | output | 24 | Frequency word to the oscillator, held while coasting |
| integ_en | output | 1 | Loop-filter integrator update enable |

## Verification
The assertions assume `acr_strobe`, `mask_we`, `cause_clr` and `fs_tick` are synchronous single-cycle strobes and that the status levels are already synchronised to `clk`, so a change of `port_sel` or `clk_det` is seen for whole cycles. The stimulus drives every input on the falling edge, raises each strobe for exactly one cycle, spaces `fs_tick` at one cycle in four, and holds `release_ticks` constant while a release count runs.

// File: rtl/coast_pkg.sv
package coast_pkg;
  localparam int NCAUSE   = 7;
  localparam int B_NOCLK  = 0;
  localparam int B_PORT   = 1;
  localparam int B_NCHG   = 2;
  localparam int B_CTS    = 3;
  localparam int B_RSVD   = 4;
  localparam int B_UNLOCK = 5;
  localparam int B_IRREG  = 6;

  typedef logic [NCAUSE-1:0] cause_t;

  // bits that carry a real cause; the reserved position is never set
  localparam cause_t CAUSE_IMPL = cause_t'(7'b1101111);
endpackage

// File: rtl/coast_event_detect.sv
module coast_event_detect
  import coast_pkg::*;
#(
  parameter int CTS_W  = 20,
  parameter int N_W    = 20,
  parameter int THR_W  = 6,
  parameter int PORT_W = 3,
  parameter int NPORT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acr_strobe,
  input  logic [CTS_W-1:0]  cts_in,
  input  logic [N_W-1:0]    n_in,
  input  logic [THR_W-1:0]  cts_thresh,
  input  logic [PORT_W-1:0] port_sel,
  input  logic [NPORT-1:0]  clk_det,
  input  logic              pll_lock,
  input  logic              clk_irreg,
  output cause_t            raw
);
  localparam int NSEL = 2 ** PORT_W;

  logic [CTS_W-1:0]  cts_prev_q, cts_prev_d;
  logic [N_W-1:0]    n_prev_q,   n_prev_d;
  logic              acr_vld_q,  acr_vld_d;
  logic [PORT_W-1:0] port_prev_q;
  logic              port_vld_q;
  logic [NSEL-1:0]   det_ext;
  logic [CTS_W-1:0]  cts_delta;
  logic [CTS_W-1:0]  thr_ext;

  // select positions without a port report no clock
  for (genvar p = 0; p < NSEL; p++) begin : g_det
    if (p < NPORT) begin : g_real
      assign det_ext[p] = clk_det[p];
    end else begin : g_none
      assign det_ext[p] = 1'b0;
    end
  end

  assign thr_ext   = {{(CTS_W-THR_W){1'b0}}, cts_thresh};
  assign cts_delta = (cts_in >= cts_prev_q) ? (cts_in - cts_prev_q)
                                            : (cts_prev_q - cts_in);

  always_comb begin
    raw            = '0;
    raw[B_IRREG]   = clk_irreg;
    raw[B_UNLOCK]  = ~pll_lock;
    raw[B_CTS]     = acr_strobe & acr_vld_q & (cts_delta > thr_ext);
    raw[B_NCHG]    = acr_strobe & acr_vld_q & (n_in != n_prev_q);
    raw[B_PORT]    = port_vld_q & (port_sel != port_prev_q);
    raw[B_NOCLK]   = ~det_ext[port_sel];
  end

  always_comb begin
    cts_prev_d = cts_prev_q;
    n_prev_d   = n_prev_q;
    acr_vld_d  = acr_vld_q;
    if (acr_strobe) begin
      cts_prev_d = cts_in;
      n_prev_d   = n_in;
      acr_vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_prev_q  <= '0;
      n_prev_q    <= '0;
      acr_vld_q   <= 1'b0;
      port_prev_q <= '0;
      port_vld_q  <= 1'b0;
    end else begin
      cts_prev_q  <= cts_prev_d;
      n_prev_q    <= n_prev_d;
      acr_vld_q   <= acr_vld_d;
      port_prev_q <= port_sel;
      port_vld_q  <= 1'b1;
    end
  end

  // R4
  cts_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw[B_CTS] |-> acr_strobe);
  // R5
  n_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw[B_NCHG] |-> acr_strobe);
endmodule

// File: rtl/coast_cause_reg.sv
module coast_cause_reg
  import coast_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mask_we,
  input  cause_t mask_wdata,
  input  cause_t raw,
  input  cause_t cause_clr,
  output cause_t cause_q,
  output logic   active
);
  cause_t mask_q, mask_d;
  cause_t cause_d;
  cause_t en;

  assign en     = raw & mask_q & CAUSE_IMPL;
  assign active = |en;

  always_comb begin
    mask_d  = mask_we ? (mask_wdata & CAUSE_IMPL) : mask_q;
    cause_d = (cause_q & ~cause_clr) | en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= CAUSE_IMPL;
      cause_q <= '0;
    end else begin
      mask_q  <= mask_d;
      cause_q <= cause_d;
    end
  end

  // R11
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|en) |=> ((cause_q & $past(en)) == $past(en)));
  // R3
  masked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~$past(cause_q) & ~$past(mask_q)) == '0));
endmodule

// File: rtl/coast_release_timer.sv
module coast_release_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             fs_tick,
  input  logic [CNT_W-1:0] release_ticks,
  output logic             coast
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             coast_d;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   limit;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign limit   = (release_ticks == '0) ? {{CNT_W{1'b0}}, 1'b1}
                                         : {1'b0, release_ticks};

  always_comb begin
    coast_d = coast;
    cnt_d   = cnt_q;
    if (active) begin
      coast_d = 1'b1;
      cnt_d   = '0;
    end else if (coast && fs_tick) begin
      if (cnt_inc >= limit) begin
        coast_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coast <= 1'b0;
      cnt_q <= '0;
    end else begin
      coast <= coast_d;
      cnt_q <= cnt_d;
    end
  end

  // R8
  coast_on_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> coast);
  // R9
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coast) |-> ($past(fs_tick) && !$past(active)));
endmodule

// File: rtl/audio_coast_ctrl.sv
module audio_coast_ctrl
  import coast_pkg::*;
#(
  parameter int CTS_W  = 20,
  parameter int N_W    = 20,
  parameter int THR_W  = 6,
  parameter int PORT_W = 3,
  parameter int NPORT  = 4,
  parameter int CNT_W  = 8,
  parameter int FREQ_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acr_strobe,
  input  logic [CTS_W-1:0]  cts_in,
  input  logic [N_W-1:0]    n_in,
  input  logic [THR_W-1:0]  cts_thresh,
  input  logic [PORT_W-1:0] port_sel,
  input  logic [NPORT-1:0]  clk_det,
  input  logic              pll_lock,
  input  logic              clk_irreg,
  input  logic              mask_we,
  input  logic [6:0]        mask_wdata,
  input  logic [6:0]        cause_clr,
  input  logic              fs_tick,
  input  logic [CNT_W-1:0]  release_ticks,
  input  logic [FREQ_W-1:0] freq_in,
  output logic              coast,
  output logic [6:0]        cause,
  output logic [FREQ_W-1:0] freq_out,
  output logic              integ_en
);
  cause_t            raw;
  cause_t            cause_q;
  logic              active;
  logic              coast_q;
  logic [FREQ_W-1:0] freq_q, freq_d;

  coast_event_detect #(
    .CTS_W(CTS_W), .N_W(N_W), .THR_W(THR_W), .PORT_W(PORT_W), .NPORT(NPORT)
  ) u_detect (
    .clk(clk), .rst_n(rst_n), .acr_strobe(acr_strobe), .cts_in(cts_in),
    .n_in(n_in), .cts_thresh(cts_thresh), .port_sel(port_sel),
    .clk_det(clk_det), .pll_lock(pll_lock), .clk_irreg(clk_irreg), .raw(raw)
  );

  coast_cause_reg u_cause (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .raw(raw), .cause_clr(cause_clr), .cause_q(cause_q), .active(active)
  );

  coast_release_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(active), .fs_tick(fs_tick),
    .release_ticks(release_ticks), .coast(coast_q)
  );

  // frequency word follows the filter only while tracking
  always_comb freq_d = coast_q ? freq_q : freq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freq_q <= '0;
    else        freq_q <= freq_d;
  end

  assign coast    = coast_q;
  assign cause    = cause_q;
  assign freq_out = freq_q;
  assign integ_en = ~coast_q;

  // R10
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coast_q |=> $stable(freq_out));
endmodule

// File: tb/audio_coast_ctrl_bench.sv
`timescale 1ns/1ps
module audio_coast_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acr_strobe;
  logic [19:0] cts_in, n_in;
  logic [5:0]  cts_thresh;
  logic [2:0]  port_sel;
  logic [3:0]  clk_det;
  logic        pll_lock, clk_irreg, mask_we;
  logic [6:0]  mask_wdata, cause_clr;
  logic        fs_tick;
  logic [7:0]  release_ticks;
  logic [23:0] freq_in;
  logic        coast, integ_en;
  logic [6:0]  cause;
  logic [23:0] freq_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  audio_coast_ctrl u_audio_coast_ctrl (
    .clk(clk), .rst_n(rst_n), .acr_strobe(acr_strobe), .cts_in(cts_in),
    .n_in(n_in), .cts_thresh(cts_thresh), .port_sel(port_sel),
    .clk_det(clk_det), .pll_lock(pll_lock), .clk_irreg(clk_irreg),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .cause_clr(cause_clr),
    .fs_tick(fs_tick), .release_ticks(release_ticks), .freq_in(freq_in),
    .coast(coast), .cause(cause), .freq_out(freq_out), .integ_en(integ_en)
  );

  // free-running stimulus for the sample-rate tick and the filter word
  int tick_div = 0;
  always @(negedge clk) begin
    tick_div <= (tick_div + 1) % 4;
    fs_tick  <= (tick_div == 3);
    freq_in  <= freq_in + 24'd7;
  end

  // behavioural reference, updated on every rising edge
  int m_coast, m_cause, m_mask, m_freq, m_cnt;
  int m_cts, m_n, m_vld, m_port, m_pvld;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_coast = 0; m_cause = 0; m_mask = 'h6F; m_freq = 0; m_cnt = 0;
      m_cts = 0; m_n = 0; m_vld = 0; m_port = 0; m_pvld = 0;
    end else begin
      int ev, d, lim;
      ev = 0;
      if (clk_irreg) ev |= 'h40;
      if (!pll_lock) ev |= 'h20;
      d = int'(cts_in) - m_cts;
      if (d < 0) d = -d;
      if (acr_strobe && m_vld && d > int'(cts_thresh)) ev |= 'h08;
      if (acr_strobe && m_vld && int'(n_in) != m_n) ev |= 'h04;
      if (m_pvld && int'(port_sel) != m_port) ev |= 'h02;
      if (port_sel > 3 || !clk_det[port_sel[1:0]]) ev |= 'h01;
      ev &= m_mask;
      if (!m_coast) m_freq = int'(freq_in);
      lim = (release_ticks == 0) ? 1 : int'(release_ticks);
      if (ev != 0) begin
        m_coast = 1; m_cnt = 0;
      end else if (m_coast && fs_tick) begin
        m_cnt++;
        if (m_cnt >= lim) begin m_coast = 0; m_cnt = 0; end
      end
      m_cause = (m_cause & ~int'(cause_clr)) | ev;
      if (mask_we) m_mask = int'(mask_wdata) & 'h6F;
      if (acr_strobe) begin m_cts = int'(cts_in); m_n = int'(n_in); m_vld = 1; end
      m_port = int'(port_sel); m_pvld = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(coast) == m_coast, "R8 model coast", int'(coast), m_coast);
      chk(int'(cause) == m_cause, "R11 model cause", int'(cause), m_cause);
      chk(int'(freq_out) == m_freq, "R10 model freq", int'(freq_out), m_freq);
      chk(integ_en == !m_coast, "R10 model integ_en", int'(integ_en), int'(!m_coast));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic strobe(input int c, input int n);
    cts_in = 20'(c); n_in = 20'(n); acr_strobe = 1'b1;
    @(negedge clk); acr_strobe = 1'b0;
  endtask

  task automatic clear(input logic [6:0] v);
    cause_clr = v; @(negedge clk); cause_clr = '0;
  endtask

  task automatic wmask(input logic [6:0] v);
    mask_wdata = v; mask_we = 1'b1; @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    clear(7'h7F);
    repeat (100) @(negedge clk);
  endtask

  initial begin
    int f0;
    rst_n = 1'b0; acr_strobe = 1'b0; cts_in = '0; n_in = '0; cts_thresh = 6'd10;
    port_sel = 3'd0; clk_det = 4'hF; pll_lock = 1'b1; clk_irreg = 1'b0;
    mask_we = 1'b0; mask_wdata = '0; cause_clr = '0; release_ticks = 8'd16;
    freq_in = '0; fs_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(coast == 1'b0, "R1 reset coast", int'(coast), 0);
    chk(cause == 7'h00, "R1 reset cause", int'(cause), 0);
    chk(integ_en == 1'b1, "R1 reset integ_en", int'(integ_en), 1);

    strobe(1000, 48);
    chk(cause == 7'h00, "R1 first strobe no event", int'(cause), 0);
    strobe(1010, 48);
    chk(cause == 7'h00, "R4 delta equal threshold", int'(cause), 0);
    strobe(999, 48);
    chk(cause == 7'h08, "R4 delta over threshold", int'(cause), 8);
    chk(coast == 1'b1, "R8 coast after cause", int'(coast), 1);

    repeat (20) @(negedge clk);
    chk(coast == 1'b1, "R9 still coasting", int'(coast), 1);
    f0 = int'(freq_out);
    repeat (5) @(negedge clk);
    chk(int'(freq_out) == f0, "R10 freq held", int'(freq_out), f0);
    chk(integ_en == 1'b0, "R10 integrator frozen", int'(integ_en), 0);
    clear(7'h08);
    chk(cause == 7'h00, "R11 write one clears", int'(cause), 0);
    repeat (80) @(negedge clk);
    chk(coast == 1'b0, "R9 released after quiet ticks", int'(coast), 0);
    chk(int'(freq_out) != f0, "R10 freq tracks again", int'(freq_out), f0);

    strobe(999, 49);
    chk(cause == 7'h04, "R5 N change", int'(cause), 4);
    settle();

    port_sel = 3'd2; @(negedge clk);
    chk(cause == 7'h02, "R6 port change", int'(cause), 2);
    settle();
    clk_det = 4'b1011; @(negedge clk);
    chk(cause == 7'h01, "R7 selected port no clock", int'(cause), 1);
    clk_det = 4'hF; settle();
    port_sel = 3'd5; @(negedge clk);
    chk(cause == 7'h03, "R7 port beyond D absent", int'(cause), 3);
    port_sel = 3'd0; settle();

    pll_lock = 1'b0; @(negedge clk);
    chk(cause == 7'h20, "R2 unlock bit 5", int'(cause), 'h20);
    pll_lock = 1'b1; settle();
    clk_irreg = 1'b1; @(negedge clk);
    chk(cause == 7'h40, "R2 irregular bit 6", int'(cause), 'h40);
    clear(7'h40);
    chk(cause == 7'h40, "R11 set wins over clear", int'(cause), 'h40);
    clk_irreg = 1'b0; settle();

    wmask(7'h10);
    clk_irreg = 1'b1; pll_lock = 1'b0; clk_det = 4'h0; port_sel = 3'd3;
    strobe(5000, 7);
    repeat (3) @(negedge clk);
    chk(coast == 1'b0, "R3 masked causes ignored", int'(coast), 0);
    chk(cause == 7'h00, "R2 reserved bit no effect", int'(cause), 0);
    wmask(7'h7F);
    @(negedge clk);
    chk(coast == 1'b1, "R3 unmasked causes coast", int'(coast), 1);
    chk(cause == 7'h61, "R2 level causes", int'(cause), 'h61);
    clk_irreg = 1'b0; pll_lock = 1'b1; clk_det = 4'hF; port_sel = 3'd0;
    settle();

    port_sel = 3'd1; @(negedge clk);
    repeat (40) @(negedge clk);
    port_sel = 3'd0; @(negedge clk);
    repeat (40) @(negedge clk);
    chk(coast == 1'b1, "R9 count restarts on cause", int'(coast), 1);
    repeat (60) @(negedge clk);
    chk(coast == 1'b0, "R9 release after restart", int'(coast), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule